// File: doc/BRIEF.md
# Receive FIFO Watermark DMA Requester

This block decides when the receive side of a network controller asks the DMA engine to move frame bytes out of its receive FIFO. It follows two byte counts for the current frame. One is a guard count of bytes written since the frame started. The other is the fill level, which is bytes written minus bytes drained. A host-programmable 2-bit watermark code sets how full the FIFO must be before a request goes out.

No request is made for a frame until 64 of its bytes have arrived. This hides short frames and frames that collide early from the DMA engine. When short-frame acceptance is enabled, a frame that ends with good status also qualifies, whatever its length. Once a frame has ended and has qualified, the request stays up until the FIFO is empty, so the tail of the frame is flushed.

The watermark code can only be written while the controller is stopped. It returns to its 64-byte setting on hardware or software reset.

Top module: `rx_wm_dmareq`

## Requirements
- R1: Watermark code `00` needs a fill level of 16 bytes, `01` needs 32, and `10` needs 64. The reserved code `11` is treated as 64.
- R2: The watermark code is `10` after `rst_n` is low or after `sw_rst` is pulsed. Raising or lowering `stop` on its own never changes it.
- R3: A write (`reg_wr`) loads `reg_wdata[13:12]` into the watermark code only while `stop` is high. When `stop` is low the write is ignored.
- R4: `reg_rdata` has bits 15:14 set to ones and the watermark code in bits 13:12. All other bits are zero.
- R5: `dma_req` stays low until the current frame has received 64 bytes. This holds even when the watermark is lower than 64, unless R8 applies.
- R6: Once 64 bytes have arrived, and while the frame is still open, `dma_req` is high exactly when the fill level is at or above the watermark.
- R7: After `frame_eof` for a qualified frame, `dma_req` stays high while the fill level is not zero. It drops in the cycle the fill level reaches zero.
- R8: If `runt_acc_en` is high and `frame_eof` arrives with `frame_good` high, the frame qualifies whatever its length. `dma_req` then rises in the next cycle if bytes remain.
- R9: A frame of fewer than 64 bytes that ends with `frame_good` low never raises `dma_req`. A short frame that ends good while `runt_acc_en` is low never raises it either.
- R10: `frame_sof` clears the guard count, the fill level and the qualified and ended state. `dma_req` is low in the following cycle.
- R11: Draining below the watermark before the frame ends drops `dma_req`. Writing back up to the watermark raises it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Synchronous software reset; also resets the watermark |
| stop | input | 1 | Controller-stopped flag; enables register writes |
| byte_wr | input | 1 | One byte written into the receive FIFO |
| byte_rd | input | 1 | One byte drained by DMA |
| frame_sof | input | 1 | Start of a new frame |
| frame_eof | input | 1 | End of the current frame |
| frame_good | input | 1 | Frame status, valid with `frame_eof` |
| runt_acc_en | input | 1 | Accept short good frames |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read-back |
| dma_req | output | 1 | Receive DMA request |

## Verification
A wrong guard count shows up as `dma_req` rising one write too early or too late around the 64th byte of a frame. A wrong fill level shows up as the request dropping at the wrong drain step, whether below the watermark or at empty. A qualified flag that is not cleared at frame start shows up in the cycle after `frame_sof`, as a request with no bytes present. A watermark decode or write-gating fault shows up at once on `reg_rdata`. It also moves the drain step at which the request drops.

// File: rtl/rx_wm_dmareq.sv
module rx_wm_dmareq #(
  parameter int FIFO_BYTES  = 128,
  parameter int GUARD_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_rst,
  input  logic        stop,
  input  logic        byte_wr,
  input  logic        byte_rd,
  input  logic        frame_sof,
  input  logic        frame_eof,
  input  logic        frame_good,
  input  logic        runt_acc_en,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        dma_req
);
  localparam int FW = $clog2(FIFO_BYTES + 1);
  localparam int GW = $clog2(GUARD_BYTES + 1);
  localparam logic [FW-1:0] FILL_MAX = FW'(FIFO_BYTES);
  localparam logic [GW-1:0] GUARD_FULL = GW'(GUARD_BYTES);

  logic [1:0]    wm_q;
  logic [FW-1:0] fill_q;
  logic [GW-1:0] guard_q;
  logic          runt_ok_q;
  logic          done_q;
  logic [FW-1:0] wm_bytes;
  logic          guard_full;

  always_comb begin
    case (wm_q)
      2'b00:   wm_bytes = FW'(16);
      2'b01:   wm_bytes = FW'(32);
      default: wm_bytes = FW'(64);
    endcase
  end

  assign guard_full = (guard_q == GUARD_FULL);
  assign dma_req    = (guard_full || runt_ok_q) &&
                      ((fill_q >= wm_bytes) || (done_q && fill_q != '0));
  assign reg_rdata  = {2'b11, wm_q, 12'h000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wm_q <= 2'b10;
    else if (sw_rst)
      wm_q <= 2'b10;
    else if (reg_wr && stop)
      wm_q <= reg_wdata[13:12];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q    <= '0;
      guard_q   <= '0;
      runt_ok_q <= 1'b0;
      done_q    <= 1'b0;
    end else if (sw_rst || frame_sof) begin
      fill_q    <= '0;
      guard_q   <= '0;
      runt_ok_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      if (byte_wr && !guard_full)
        guard_q <= guard_q + 1'b1;
      if (byte_wr && !byte_rd && fill_q != FILL_MAX)
        fill_q <= fill_q + 1'b1;
      else if (byte_rd && !byte_wr && fill_q != '0)
        fill_q <= fill_q - 1'b1;
      if (frame_eof) begin
        done_q <= 1'b1;
        if (frame_good && runt_acc_en)
          runt_ok_q <= 1'b1;
      end
    end
  end
endmodule

module rx_wm_dmareq_chk #(
  parameter int FW = 8,
  parameter int GW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_rst,
  input logic          stop,
  input logic          frame_sof,
  input logic          frame_eof,
  input logic          frame_good,
  input logic          dma_req,
  input logic [15:0]   reg_rdata,
  input logic [FW-1:0] fill,
  input logic          guard_full
);
  // R7
  req_has_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> fill != '0);
  // R10
  sof_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sof |=> !dma_req);
  // R3
  locked_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop && !sw_rst) |=> $stable(reg_rdata));
  // R2
  swrst_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> reg_rdata[13:12] == 2'b10);
  // R9
  bad_short_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_eof && !frame_good && !guard_full && !frame_sof && !dma_req) |=> !dma_req);
endmodule

bind rx_wm_dmareq rx_wm_dmareq_chk #(.FW(FW), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .stop(stop),
  .frame_sof(frame_sof), .frame_eof(frame_eof), .frame_good(frame_good),
  .dma_req(dma_req), .reg_rdata(reg_rdata), .fill(fill_q),
  .guard_full(guard_full)
);

// File: tb/test_rx_wm_dmareq.sv
module test_rx_wm_dmareq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_rst = 0, stop = 0, byte_wr = 0, byte_rd = 0;
  logic frame_sof = 0, frame_eof = 0, frame_good = 0, runt_acc_en = 0;
  logic reg_wr = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic dma_req;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  rx_wm_dmareq i_rx_wm_dmareq (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .stop(stop),
    .byte_wr(byte_wr), .byte_rd(byte_rd), .frame_sof(frame_sof),
    .frame_eof(frame_eof), .frame_good(frame_good), .runt_acc_en(runt_acc_en),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input int n);
    byte_wr = 1; repeat (n) tick(); byte_wr = 0;
  endtask

  task automatic pull(input int n);
    byte_rd = 1; repeat (n) tick(); byte_rd = 0;
  endtask

  task automatic sof();
    frame_sof = 1; tick(); frame_sof = 0;
  endtask

  task automatic eof(input logic good);
    frame_eof = 1; frame_good = good; tick(); frame_eof = 0; frame_good = 0;
  endtask

  task automatic set_wm(input logic [1:0] code);
    stop = 1; reg_wr = 1; reg_wdata = {2'b00, code, 12'h000}; tick();
    reg_wr = 0; stop = 0;
  endtask

  task automatic t_reset();
    chk("R2 reset code", reg_rdata, 16'hE000);
    chk("R4 layout", {15'd0, dma_req}, 16'd0);
  endtask

  task automatic t_reg();
    stop = 0; reg_wr = 1; reg_wdata = 16'h0000; tick(); reg_wr = 0;
    chk("R3 write ignored while running", reg_rdata, 16'hE000);
    stop = 1; reg_wr = 1; reg_wdata = 16'hFFFF & 16'h0FFF; tick(); reg_wr = 0;
    chk("R4 read-back fields", reg_rdata, 16'h0000 | 16'hC000);
    stop = 0; tick();
    chk("R2 stop leaves code", reg_rdata, 16'hC000);
    set_wm(2'b11);
    chk("R4 reserved code read-back", reg_rdata, 16'hF000);
    stop = 1; sw_rst = 1; tick(); sw_rst = 0; stop = 0;
    chk("R2 software reset", reg_rdata, 16'hE000);
  endtask

  task automatic t_guard();
    set_wm(2'b00);
    sof(); push(63);
    chk("R5 no request at 63 bytes", {15'd0, dma_req}, 16'd0);
    push(1);
    chk("R6 request at 64 bytes", {15'd0, dma_req}, 16'd1);
    pull(48);
    chk("R6 fill 16 keeps request", {15'd0, dma_req}, 16'd1);
    pull(1);
    chk("R11 below watermark drops", {15'd0, dma_req}, 16'd0);
    push(1);
    chk("R11 refill raises", {15'd0, dma_req}, 16'd1);
    eof(1);
    pull(15);
    chk("R7 flush with 1 byte left", {15'd0, dma_req}, 16'd1);
    pull(1);
    chk("R7 drops at empty", {15'd0, dma_req}, 16'd0);
  endtask

  task automatic t_codes();
    set_wm(2'b01);
    sof(); push(64);
    pull(32);
    chk("R1 code 01 at fill 32", {15'd0, dma_req}, 16'd1);
    pull(1);
    chk("R1 code 01 at fill 31", {15'd0, dma_req}, 16'd0);
    set_wm(2'b11);
    sof(); push(63);
    chk("R1 code 11 at 63", {15'd0, dma_req}, 16'd0);
    push(1);
    chk("R1 code 11 at 64", {15'd0, dma_req}, 16'd1);
    pull(1);
    chk("R1 code 11 fill 63", {15'd0, dma_req}, 16'd0);
    set_wm(2'b10);
    sof(); push(70);
    pull(6);
    chk("R1 code 10 fill 64", {15'd0, dma_req}, 16'd1);
    pull(1);
    chk("R1 code 10 fill 63", {15'd0, dma_req}, 16'd0);
  endtask

  task automatic t_runt();
    set_wm(2'b00);
    runt_acc_en = 1;
    sof(); push(20);
    chk("R8 open short frame silent", {15'd0, dma_req}, 16'd0);
    eof(1);
    chk("R8 good short frame requests", {15'd0, dma_req}, 16'd1);
    pull(20);
    chk("R8 drops when drained", {15'd0, dma_req}, 16'd0);
    sof(); push(20); eof(0);
    chk("R9 bad short frame silent", {15'd0, dma_req}, 16'd0);
    runt_acc_en = 0;
    sof(); push(20); eof(1);
    chk("R9 good short without accept", {15'd0, dma_req}, 16'd0);
  endtask

  task automatic t_sof();
    set_wm(2'b00);
    sof(); push(64);
    chk("R10 request before restart", {15'd0, dma_req}, 16'd1);
    sof();
    chk("R10 start clears request", {15'd0, dma_req}, 16'd0);
    push(63);
    chk("R10 guard restarted", {15'd0, dma_req}, 16'd0);
    push(1);
    chk("R10 guard reached again", {15'd0, dma_req}, 16'd1);
  endtask

  initial begin
    #1;
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset();
    t_reg();
    t_guard();
    t_codes();
    t_runt();
    t_sof();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule